// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is a two-wire serial slave that sits inside a clock generator and owns its bank of 8-bit configuration bytes. It watches the clock and data lines, finds start and stop conditions, matches its fixed 7-bit device address, takes a command code, and then moves data bytes into or out of the bank. It answers on the data line only by pulling it low through an open-drain enable. The whole bank is presented in parallel to the rest of the chip, so that the output-enable bits take effect at once. One bit is also brought out on its own: the one that picks the alternate frequency table.

The command code has two forms. With its top bit set, its low seven bits index a single byte for a read or a write. With its top bit clear, the transfer is a block transfer that always starts at byte 0. A block write carries a byte count first, which is acknowledged and then dropped. A block read sends a byte count first and then the bytes in rising order, for as long as the master keeps acknowledging. Reads use a repeated start with the read form of the address. Both line inputs are synchronised to the system clock and cleaned by a three-sample majority vote before any edge, start or stop is decoded.

Top module: `smbCfgSlave`

## Requirements
- R1: After reset, `regBank` equals `REG_INIT` (default: every byte 8'hFF except byte 6, which is 8'h00), `altFreqTable` is 0 and `sdaOe` is 0.
- R2: An address byte whose upper seven bits are 7'b1101001 (write form 8'hD2, read form 8'hD3) is acknowledged: `sdaOe` is high through the ninth clock.
- R3: Any other address byte is not acknowledged. Every following byte is ignored, with no acknowledge and no register change, until the next start condition.
- R4: A command byte with bit 7 = 1 is acknowledged and selects offset bits 6:0. The next data byte, sent MSB first, is acknowledged and stored at that offset.
- R5: A command byte with bit 7 = 1, followed by a repeated start and address 8'hD3, returns the byte at that offset MSB first. The slave stops driving when the master does not acknowledge.
- R6: A block write (command 8'h00) acknowledges a count byte that is not stored, then stores the data bytes at offsets 0, 1, 2 and so on. A stop after any complete byte leaves the later bytes unchanged.
- R7: A block read (command 8'h00, repeated start, 8'hD3) returns the byte count `NUM_REGS` first, then bytes 0, 1, 2 and so on, one for each master acknowledge.
- R8: `altFreqTable` follows byte 6 bit 5 of the bank after every write to that byte.
- R9: A write to an offset at or above `NUM_REGS` changes nothing. A read from such an offset returns 8'h00.
- R10: A pulse on SCL or SDA that lasts one system-clock sample is ignored. It causes no extra bit, no start and no stop.
- R11: `sdaOe` is released after a stop condition, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous power-up reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | High pulls the data line low (open drain) |
| regBank | output | NUM_REGS*8 | All configuration bytes, byte 0 in the low bits |
| altFreqTable | output | 1 | Alternate frequency table select (byte 6 bit 5) |

## Verification
The assertions assume a well-behaved master. It holds SCL low for several system clocks after each falling edge before the slave's response could matter. It changes SDA only while SCL is low, except to form a start or a stop. It never issues a start or a stop while the slave is pulling SDA low. The bench drives the bus with a quarter-bit period of twelve system clocks, which is far longer than the synchroniser and filter delay. Its only excursions are deliberate glitches one clock wide, used to show that the filter rejects them. Those glitches leave SCL low only while the slave's drive is steady, so the SCL-low rule for `sdaOe` still holds.

// File: rtl/smbCfgPkg.sv
package smbCfgPkg;
  typedef struct packed {
    logic shiftIn;
    logic capCmd;
    logic storeByte;
    logic loadTx;
    logic shiftTx;
  } ctrlStb_t;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} busState_t;
  typedef enum logic [1:0] {R_ADDR, R_CMD, R_DATA} byteRole_t;
endpackage

// File: rtl/smbCfgFilter.sv
module smbCfgFilter (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int LINES = 2;
  logic [LINES-1:0] rawIn, lvl, prevLvl;
  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0] syncQ;
    logic [2:0] hist;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ      <= '1;
        hist       <= '1;
        lvl[g]     <= 1'b1;
        prevLvl[g] <= 1'b1;
      end else begin
        syncQ      <= {syncQ[0], rawIn[g]};
        hist       <= {hist[1:0], syncQ[1]};
        lvl[g]     <= (hist[0] & hist[1]) | (hist[1] & hist[2]) | (hist[0] & hist[2]);
        prevLvl[g] <= lvl[g];
      end
    end
  end

  assign sdaLvl   = lvl[1];
  assign sclRise  = lvl[0] & ~prevLvl[0];
  assign sclFall  = ~lvl[0] & prevLvl[0];
  assign startDet = lvl[0] & prevLvl[0] & prevLvl[1] & ~lvl[1];
  assign stopDet  = lvl[0] & prevLvl[0] & ~prevLvl[1] & lvl[1];
endmodule

// File: rtl/smbCfgCtrl.sv
module smbCfgCtrl
  import smbCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output ctrlStb_t   stb,
  output logic       sdaOe
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  busState_t  state;
  byteRole_t  role;
  logic [3:0] bitCnt;
  logic       ackDrive, isRead, mAck;
  logic       byteDone;

  assign byteDone = sclFall && (bitCnt == BYTE_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      role     <= R_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
    end else if (startDet) begin
      state    <= S_RX;
      role     <= R_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= S_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (byteDone) begin
            bitCnt <= '0;
            if (role == R_ADDR && rxByte[7:1] != DEV_ADDR) state <= S_IDLE;
            else begin
              state    <= S_RXACK;
              ackDrive <= 1'b1;
              if (role == R_ADDR) isRead <= rxByte[0];
            end
          end
        end
        S_RXACK: if (sclFall) begin
          ackDrive <= 1'b0;
          if (role == R_ADDR && isRead) state <= S_TX;
          else begin
            state <= S_RX;
            role  <= (role == R_ADDR) ? R_CMD : R_DATA;
          end
        end
        S_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (byteDone) begin
            bitCnt <= '0;
            state  <= S_TXACK;
          end
        end
        S_TXACK: begin
          if (sclRise) mAck <= ~sdaLvl;
          else if (sclFall) state <= mAck ? S_TX : S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.shiftIn   = (state == S_RX) && sclRise;
    stb.capCmd    = (state == S_RX) && byteDone && role == R_CMD;
    stb.storeByte = (state == S_RX) && byteDone && role == R_DATA;
    stb.loadTx    = ((state == S_RXACK) && sclFall && role == R_ADDR && isRead)
                  || ((state == S_TXACK) && sclFall && mAck);
    stb.shiftTx   = (state == S_TX) && sclFall && (bitCnt != BYTE_BITS);
    if (startDet || stopDet) stb = '0;
  end

  assign sdaOe = ackDrive | ((state == S_TX) & ~txBit);
endmodule

// File: rtl/smbCfgData.sv
module smbCfgData
  import smbCfgPkg::*;
#(
  parameter int                      NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0]   REG_INIT = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStb_t              stb,
  input  logic                  sdaLvl,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regBank
);
  localparam int PTR_W = 7;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0]       regs [NUM_REGS];
  logic [7:0]       rxSr, txSr;
  logic [PTR_W-1:0] ptr;
  logic             cntNext, inRange;
  logic [IDX_W-1:0] idx;

  assign inRange = ptr < PTR_W'(NUM_REGS);
  assign idx     = ptr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSr <= '0;
    else if (stb.shiftIn) rxSr <= {rxSr[6:0], sdaLvl};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= REG_INIT[i*8 +: 8];
      txSr    <= '0;
      ptr     <= '0;
      cntNext <= 1'b0;
    end else begin
      if (stb.capCmd) begin
        cntNext <= ~rxSr[7];
        ptr     <= rxSr[7] ? rxSr[6:0] : '0;
      end
      if (stb.storeByte) begin
        if (cntNext) cntNext <= 1'b0;
        else begin
          if (inRange) regs[idx] <= rxSr;
          ptr <= ptr + 1'b1;
        end
      end
      if (stb.loadTx) begin
        if (cntNext) begin
          txSr    <= 8'(NUM_REGS);
          cntNext <= 1'b0;
        end else begin
          txSr <= inRange ? regs[idx] : 8'h00;
          ptr  <= ptr + 1'b1;
        end
      end
      if (stb.shiftTx) txSr <= {txSr[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regBank[g*8 +: 8] = regs[g];
  end

  assign rxByte = rxSr;
  assign txBit  = txSr[7];
endmodule

// File: rtl/smbCfgSlave.sv
module smbCfgSlave
  import smbCfgPkg::*;
#(
  parameter logic [6:0]            DEV_ADDR = 7'h69,
  parameter int                    NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = 64'hFF00_FFFF_FFFF_FFFF,
  parameter int                    ALT_BYTE = 6,
  parameter int                    ALT_BIT  = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regBank,
  output logic                  altFreqTable
);
  localparam int ALT_POS = ALT_BYTE * 8 + ALT_BIT;

  logic       sdaLvl, sclRise, sclFall, startDet, stopDet, txBit;
  logic [7:0] rxByte;
  ctrlStb_t   stb;

  smbCfgFilter filt_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smbCfgCtrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  smbCfgData #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txBit(txBit), .regBank(regBank)
  );

  assign altFreqTable = regBank[ALT_POS];
endmodule

// File: rtl/smbCfgChecker.sv
module smbCfgChecker
  import smbCfgPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic                  stopDet,
  input ctrlStb_t              stb,
  input logic [NUM_REGS*8-1:0] regBank
);
  AST_BANK_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.storeByte |=> $stable(regBank)); // R4
  AST_CMD_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    stb.capCmd |=> sdaOe); // R4
  AST_STORE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |-> !sdaOe); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R11
  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R11
endmodule

bind smbCfgSlave smbCfgChecker #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .stopDet(stopDet), .stb(stb), .regBank(regBank)
);

// File: tb/smbCfgSlave_tb_top.sv
`timescale 1ns/1ps
module smbCfgSlave_tb_top;
  localparam int NREG = 8;
  localparam int Q    = 12;
  localparam logic [NREG*8-1:0] INIT = 64'hFF00_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sdaM = 1'b1;
  logic sdaOe, altFreqTable;
  logic [NREG*8-1:0] regBank;
  logic sdaBus;
  logic [7:0] model [NREG];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  smbCfgSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regBank(regBank), .altFreqTable(altFreqTable)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); scl = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); scl = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q); scl = 1'b1; tick(Q);
      if (glitch && i == 3) begin
        scl = 1'b0; tick(1); scl = 1'b1; tick(1);
        sdaM = ~b[i]; tick(1); sdaM = b[i]; tick(1);
      end
      tick(Q); scl = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = (sdaBus == 1'b0);
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sdaBus; tick(Q); scl = 1'b0; tick(Q);
    end
    sdaM = giveAck ? 1'b0 : 1'b1;
    tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  function automatic logic [NREG*8-1:0] modelBank();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic writeByte(input logic [6:0] off, input logic [7:0] val, input bit glitch, input string req);
    bit a;
    busStart();
    sendByte(8'hD2, 1'b0, a); chk(a, "R2 write address ack", a, 1);
    sendByte({1'b1, off}, 1'b0, a); chk(a, {req, " command ack"}, a, 1);
    sendByte(val, glitch, a); chk(a, {req, " data ack"}, a, 1);
    busStop();
    if (off < NREG) model[off] = val;
    chk(regBank == modelBank(), {req, " bank after byte write"}, regBank, modelBank());
  endtask

  task automatic readByte(input logic [6:0] off, input logic [7:0] exp, input string req);
    bit a;
    logic [7:0] got;
    busStart();
    sendByte(8'hD2, 1'b0, a);
    sendByte({1'b1, off}, 1'b0, a);
    busStart();
    sendByte(8'hD3, 1'b0, a); chk(a, "R2 read address ack", a, 1);
    recvByte(1'b0, got);
    chk(got == exp, {req, " byte read value"}, got, exp);
    chk(sdaOe == 1'b0, "R5 released after NACK", sdaOe, 0);
    busStop();
    chk(sdaOe == 1'b0, "R11 released after stop", sdaOe, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) model[i] = INIT[i*8 +: 8];
    chk(regBank == INIT, "R1 reset bank", regBank, INIT);
    chk(altFreqTable == 1'b0, "R1 reset alt select", altFreqTable, 0);
    chk(sdaOe == 1'b0, "R1 reset sdaOe", sdaOe, 0);
  endtask

  task automatic t_badAddr();
    bit a;
    busStart();
    sendByte(8'hA4, 1'b0, a); chk(!a, "R3 foreign address not acked", a, 0);
    sendByte(8'h81, 1'b0, a); chk(!a, "R3 command ignored", a, 0);
    sendByte(8'h5A, 1'b0, a); chk(!a, "R3 data ignored", a, 0);
    busStop();
    chk(regBank == modelBank(), "R3 bank unchanged", regBank, modelBank());
  endtask

  task automatic t_blockWrite();
    bit a;
    busStart();
    sendByte(8'hD2, 1'b0, a);
    sendByte(8'h00, 1'b0, a); chk(a, "R6 block command ack", a, 1);
    sendByte(8'h03, 1'b0, a); chk(a, "R6 count ack", a, 1);
    sendByte(8'h11, 1'b0, a); sendByte(8'h22, 1'b0, a); sendByte(8'h33, 1'b0, a);
    chk(a, "R6 last data ack", a, 1);
    busStop();
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    chk(regBank == modelBank(), "R6 block write bank", regBank, modelBank());
  endtask

  task automatic t_blockRead();
    bit a;
    logic [7:0] got;
    busStart();
    sendByte(8'hD2, 1'b0, a);
    sendByte(8'h00, 1'b0, a);
    busStart();
    sendByte(8'hD3, 1'b0, a);
    recvByte(1'b1, got); chk(got == NREG, "R7 block count", got, NREG);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, got);
      chk(got == model[i], "R7 block byte", got, model[i]);
    end
    busStop();
    chk(sdaOe == 1'b0, "R11 released after block read", sdaOe, 0);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    t_reset();
    writeByte(7'd3, 8'hA5, 1'b0, "R4");
    readByte(7'd3, 8'hA5, "R5");
    t_badAddr();
    t_blockWrite();
    t_blockRead();
    writeByte(7'd6, 8'h20, 1'b0, "R8");
    chk(altFreqTable == 1'b1, "R8 alt select set", altFreqTable, 1);
    writeByte(7'd6, 8'hDF, 1'b0, "R8");
    chk(altFreqTable == 1'b0, "R8 alt select clear", altFreqTable, 0);
    writeByte(7'h10, 8'h77, 1'b0, "R9");
    readByte(7'h10, 8'h00, "R9");
    writeByte(7'd5, 8'h3C, 1'b1, "R10");
    readByte(7'd5, 8'h3C, "R10");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule